// File: doc/BRIEF.md
# Balanced Ternary Add/Subtract Unit

This block is a purely combinational adder for signed words in balanced ternary. Each digit (trit) is -1, 0 or +1 and travels on a two-bit code. A word of `N` trits (default 3) represents the integer sum of trit_i * 3^i. The range is -(3^N-1)/2 to +(3^N-1)/2.

A three-valued operation input scales the second operand B by -1, 0 or +1 before it is added to A. The same datapath therefore performs A+B, A-B, or a pass-through of A. The scaled operand enters a ripple chain. A half adder sits at the least significant trit and full adders sit above it. Each full adder is two cascaded trit half adders whose two partial carries merge into one carry trit. The carry needs no lookahead, so the delay grows linearly with `N`.

With `OVF_EN` set, the top trit keeps its carry, and that carry comes out as a signed overflow trit. With `OVF_EN` cleared, the top trit only forms its sum and the result wraps modulo 3^N. The undefined code on any input is read as zero and raises an error output.

Top module: `bt_addsub`

## Requirements
- R1: Trit codes are 2'b00 = zero, 2'b01 = +1 and 2'b11 = -1. Trit i of a word occupies bits [2i+1:2i] and weighs 3^i. The operation input `op_i` is a single trit in the same code.
- R2: `res_o` and `ovf_o` never carry the code 2'b10.
- R3: With `op_i` = +1, `res_o` equals A+B reduced into the range -(3^N-1)/2 .. +(3^N-1)/2.
- R4: With `op_i` = 0, `res_o` equals A and `ovf_o` is zero, whatever B holds.
- R5: With `op_i` = -1, `res_o` equals A-B reduced into the same balanced range.
- R6: With `OVF_EN` = 1, the relation value(res_o) + value(ovf_o) * 3^N equals the exact result. `ovf_o` is +1 above the range, -1 below it, and zero inside it.
- R7: A carry produced at trit 0 ripples through every trit. For example, A = all +1 with B = +1 and `op_i` = +1 wraps to all -1 with `ovf_o` = +1.
- R8: The code 2'b10 on any trit of A, B or `op_i` is taken as zero, and `err_o` is 1. `err_o` is 0 when all inputs are legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 2*N | Operand A, N trits |
| b_i | input | 2*N | Operand B, N trits |
| op_i | input | 2 | Trit scaling B: -1 subtract, 0 pass A, +1 add |
| res_o | output | 2*N | N-trit result |
| ovf_o | output | 2 | Signed overflow trit (zero when OVF_EN = 0) |
| err_o | output | 1 | An input carried the undefined code |

## Verification
The bench sweeps every pair of 3-trit operands under each of the three operation codes. The add sweep separates carry generation of both signs from the trit sum table. The subtract sweep exposes errors in the per-trit negation, and the pass sweep shows that B has no path to the result when the operation is zero. Directed patterns of all +1 and all -1 push a carry through the full chain in both directions, which tells a broken link between stages apart from a broken stage. The undefined code is then placed separately on A, on B and on the operation input, which shows that each is read as zero and flagged.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t T_ZERO = 2'b00;
    localparam trit_t T_POS  = 2'b01;
    localparam trit_t T_NEG  = 2'b11;
    localparam trit_t T_BAD  = 2'b10;

    // Undefined code reads as zero.
    function automatic trit_t trit_clean(trit_t t);
        return (t == T_BAD) ? T_ZERO : t;
    endfunction

    function automatic logic trit_is_bad(trit_t t);
        return t == T_BAD;
    endfunction

    // Signed value of a (clean) trit.
    function automatic logic signed [2:0] trit_val(trit_t t);
        case (t)
            T_POS:   return 3'sd1;
            T_NEG:   return -3'sd1;
            default: return 3'sd0;
        endcase
    endfunction

    // Encode a small signed value that is already in -1..+1.
    function automatic trit_t trit_enc(logic signed [2:0] v);
        case (v)
            3'sd1:   return T_POS;
            -3'sd1:  return T_NEG;
            default: return T_ZERO;
        endcase
    endfunction

    // Modulo-3 balanced sum digit of two trits.
    function automatic trit_t trit_sum(trit_t x, trit_t y);
        logic signed [2:0] s;
        s = trit_val(x) + trit_val(y);
        case (s)
            3'sd2:   return T_NEG;
            -3'sd2:  return T_POS;
            default: return trit_enc(s);
        endcase
    endfunction

    // Carry digit of two trits: nonzero only when both match and are nonzero.
    function automatic trit_t trit_carry(trit_t x, trit_t y);
        return (x == y && x != T_ZERO) ? x : T_ZERO;
    endfunction

endpackage

// File: rtl/bt_sign_ctrl.sv
module bt_sign_ctrl
    import bt_pkg::*;
(
    input  trit_t op_i,
    input  trit_t b_i,
    output trit_t q_o
);
    trit_t q_d;

    // Product of control trit and data trit.
    always_comb begin
        q_d = T_ZERO;
        if (op_i == T_POS)
            q_d = b_i;
        else if (op_i == T_NEG && b_i != T_ZERO)
            q_d = {~b_i[1], b_i[0]};
    end

    assign q_o = q_d;
endmodule

// File: rtl/bt_half_add.sv
module bt_half_add
    import bt_pkg::*;
(
    input  trit_t x_i,
    input  trit_t y_i,
    output trit_t sum_o,
    output trit_t carry_o
);
    assign sum_o   = trit_sum(x_i, y_i);
    assign carry_o = trit_carry(x_i, y_i);
endmodule

// File: rtl/bt_full_add.sv
module bt_full_add
    import bt_pkg::*;
(
    input  trit_t x_i,
    input  trit_t y_i,
    input  trit_t cin_i,
    output trit_t sum_o,
    output trit_t cout_o
);
    trit_t part_s, c_lo, c_hi;

    bt_half_add u_ha_xy (
        .x_i     (x_i),
        .y_i     (y_i),
        .sum_o   (part_s),
        .carry_o (c_lo)
    );

    bt_half_add u_ha_c (
        .x_i     (part_s),
        .y_i     (cin_i),
        .sum_o   (sum_o),
        .carry_o (c_hi)
    );

    // The two partial carries never share a sign, so their sum fits one trit.
    assign cout_o = trit_enc(trit_val(c_lo) + trit_val(c_hi));
endmodule

// File: rtl/bt_addsub.sv
module bt_addsub
    import bt_pkg::*;
#(
    parameter int N      = 3,
    parameter bit OVF_EN = 1'b1
) (
    input  logic [2*N-1:0] a_i,
    input  logic [2*N-1:0] b_i,
    input  logic [1:0]     op_i,
    output logic [2*N-1:0] res_o,
    output logic [1:0]     ovf_o,
    output logic           err_o
);
    localparam int TOP = N - 1;

    trit_t            op_c;
    trit_t [N-1:0]    a_c, b_c, q, sum, carry;
    logic  [N-1:0]    bad_a, bad_b;

    assign op_c = trit_clean(op_i);

    for (genvar i = 0; i < N; i++) begin : g_trit
        assign a_c[i]   = trit_clean(a_i[2*i +: 2]);
        assign b_c[i]   = trit_clean(b_i[2*i +: 2]);
        assign bad_a[i] = trit_is_bad(a_i[2*i +: 2]);
        assign bad_b[i] = trit_is_bad(b_i[2*i +: 2]);

        bt_sign_ctrl u_sign (
            .op_i (op_c),
            .b_i  (b_c[i]),
            .q_o  (q[i])
        );

        if (i == 0) begin : g_lsb
            bt_half_add u_ha (
                .x_i     (a_c[i]),
                .y_i     (q[i]),
                .sum_o   (sum[i]),
                .carry_o (carry[i])
            );
        end else if (i == TOP && !OVF_EN) begin : g_msb_wrap
            // Sum-only top trit: the result wraps modulo 3^N.
            assign sum[i]   = trit_sum(trit_sum(a_c[i], q[i]), carry[i-1]);
            assign carry[i] = T_ZERO;
        end else begin : g_mid
            bt_full_add u_fa (
                .x_i    (a_c[i]),
                .y_i    (q[i]),
                .cin_i  (carry[i-1]),
                .sum_o  (sum[i]),
                .cout_o (carry[i])
            );
        end

        assign res_o[2*i +: 2] = sum[i];
    end

    assign ovf_o = OVF_EN ? carry[TOP] : T_ZERO;
    assign err_o = (|bad_a) | (|bad_b) | trit_is_bad(op_i);

endmodule

// File: rtl/bt_addsub_chk.sv
module bt_addsub_chk
    import bt_pkg::*;
#(
    parameter int N      = 3,
    parameter bit OVF_EN = 1'b1
) (
    input logic [2*N-1:0] a_i,
    input logic [2*N-1:0] b_i,
    input logic [1:0]     op_i,
    input logic [2*N-1:0] res_o,
    input logic [1:0]     ovf_o,
    input logic           err_o
);
    function automatic int pow3(int n);
        int p = 1;
        for (int k = 0; k < n; k++) p = p * 3;
        return p;
    endfunction

    localparam int WRAP = pow3(N);

    function automatic int word_val(logic [2*N-1:0] w);
        int v = 0;
        int p = 1;
        for (int k = 0; k < N; k++) begin
            v = v + int'(trit_val(trit_clean(w[2*k +: 2]))) * p;
            p = p * 3;
        end
        return v;
    endfunction

    function automatic logic word_bad(logic [2*N-1:0] w);
        logic b = 1'b0;
        for (int k = 0; k < N; k++) b = b | (w[2*k +: 2] == T_BAD);
        return b;
    endfunction

    always_comb begin
        AST_RES_LEGAL: assert (!word_bad(res_o) && ovf_o != T_BAD); // R2
        AST_PASS_A: assert (trit_clean(op_i) != T_ZERO ||
                            (word_val(res_o) == word_val(a_i) && ovf_o == T_ZERO)); // R4
        AST_NO_OVERFLOW: assert (ovf_o == T_ZERO || (OVF_EN && trit_clean(op_i) != T_ZERO)); // R6
        AST_ERR_FLAG: assert (err_o || !(word_bad(a_i) || word_bad(b_i) || op_i == T_BAD)); // R8
    end

    if (OVF_EN) begin : g_exact
        always_comb begin
            AST_SUM_EXACT: assert (word_val(res_o) + int'(trit_val(ovf_o)) * WRAP ==
                                   word_val(a_i) + int'(trit_val(trit_clean(op_i))) * word_val(b_i)); // R3 R5 R6
        end
    end
endmodule

bind bt_addsub bt_addsub_chk #(.N(N), .OVF_EN(OVF_EN)) u_chk (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (op_i),
    .res_o (res_o),
    .ovf_o (ovf_o),
    .err_o (err_o)
);

// File: tb/bt_addsub_test.sv
module bt_addsub_test;
    localparam int N    = 3;
    localparam int WRAP = 27;
    localparam int HALF = 13;

    logic           clk = 1'b0;
    logic [2*N-1:0] a = '0;
    logic [2*N-1:0] b = '0;
    logic [1:0]     op = 2'b00;
    logic [2*N-1:0] res;
    logic [1:0]     ovf;
    logic           err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bt_addsub #(.N(N), .OVF_EN(1'b1)) uut (
        .a_i   (a),
        .b_i   (b),
        .op_i  (op),
        .res_o (res),
        .ovf_o (ovf),
        .err_o (err)
    );

    function automatic logic [2*N-1:0] enc(int v);
        logic [2*N-1:0] w = '0;
        int x = v;
        for (int k = 0; k < N; k++) begin
            int r = ((x % 3) + 3) % 3;
            if (r == 1) begin w[2*k +: 2] = 2'b01; x = (x - 1) / 3; end
            else if (r == 2) begin w[2*k +: 2] = 2'b11; x = (x + 1) / 3; end
            else x = x / 3;
        end
        return w;
    endfunction

    function automatic int tval(logic [1:0] t);
        return (t == 2'b01) ? 1 : (t == 2'b11) ? -1 : 0;
    endfunction

    function automatic int dec(logic [2*N-1:0] w);
        int v = 0;
        int p = 1;
        for (int k = 0; k < N; k++) begin
            v = v + tval(w[2*k +: 2]) * p;
            p = p * 3;
        end
        return v;
    endfunction

    function automatic logic has_bad(logic [2*N-1:0] w);
        logic f = 1'b0;
        for (int k = 0; k < N; k++) f = f | (w[2*k +: 2] == 2'b10);
        return f;
    endfunction

    function automatic int wrapv(int v);
        int r = ((v + HALF) % WRAP + WRAP) % WRAP;
        return r - HALF;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [2*N-1:0] av, input logic [2*N-1:0] bv, input logic [1:0] ov);
        @(posedge clk);
        a = av; b = bv; op = ov;
        @(negedge clk);
    endtask

    // All operand pairs under one operation code.
    task automatic sweep(input logic [1:0] ov, input int k, input string req);
        for (int x = -HALF; x <= HALF; x++) begin
            for (int y = -HALF; y <= HALF; y++) begin
                int full = x + k * y;
                int w    = wrapv(full);
                apply(enc(x), enc(y), ov);
                check(dec(res) == w, req, dec(res), w);
                check(tval(ovf) == (full - w) / WRAP, {req, "/R6 ovf"}, tval(ovf), (full - w) / WRAP);
                check(!has_bad(res) && ovf != 2'b10 && !err, {req, "/R2 R8 legal"}, int'(res), -1);
            end
        end
    endtask

    task automatic t_idle;
        apply('0, '0, 2'b00);
        check(res == '0 && ovf == 2'b00 && err == 1'b0, "R1 idle", int'(res), 0);
    endtask

    task automatic t_add;  sweep(2'b01,  1, "R3 add");  endtask
    task automatic t_pass; sweep(2'b00,  0, "R4 pass"); endtask
    task automatic t_sub;  sweep(2'b11, -1, "R5 sub");  endtask

    task automatic t_ripple;
        apply(enc(HALF), enc(1), 2'b01);
        check(dec(res) == -HALF, "R7 up ripple res", dec(res), -HALF);
        check(ovf == 2'b01, "R7 up ripple ovf", int'(ovf), 1);
        apply(enc(-HALF), enc(1), 2'b11);
        check(dec(res) == HALF, "R7 down ripple res", dec(res), HALF);
        check(ovf == 2'b11, "R7 down ripple ovf", int'(ovf), 3);
        apply(enc(1), enc(1), 2'b01);
        check(res == 6'b000111, "R1 digit +,- code", int'(res), 7);
    endtask

    task automatic t_illegal;
        apply(6'b010110, enc(5), 2'b01);   // A trit0 undefined: A reads as +1*9 + +1*3 = 12? no: trits (0b10,01,01)
        check(dec(res) == wrapv(12 + 5) && err, "R8 bad A", dec(res), wrapv(17));
        apply(enc(4), 6'b100001, 2'b01);   // B trit2 undefined: B reads as 1
        check(dec(res) == 5 && err, "R8 bad B", dec(res), 5);
        apply(enc(-7), enc(9), 2'b10);     // op undefined: acts as pass
        check(dec(res) == -7 && ovf == 2'b00 && err, "R8 bad op", dec(res), -7);
        apply(enc(-7), enc(9), 2'b11);
        check(err == 1'b0, "R8 err clears", int'(err), 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_idle();
        t_add();
        t_pass();
        t_sub();
        t_ripple();
        t_illegal();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule